// File: doc/BRIEF.md
# Four-channel parity lane serializer

This block takes four 8-bit samples, appends an odd parity bit to each, and sends the resulting 36 bits over three serial data lanes in a repeating 12-beat frame. A fourth output acts as the bit-clock lane. Lanes 0, 1 and 2 each carry one whole channel (eight data bits, least significant first, then parity) in beats 0 to 8. The fourth channel is split across all three lanes in the three tail beats 9 to 11.

The block runs on its own from reset release and needs no control. A new set of samples is taken once per frame, at the clock edge that starts a frame, and only when the valid strobe is high at that edge. Otherwise the previous set is sent again. Each lane bit is chosen by a multiplexer and then registered, so a lane holds steady for the whole bit period. A frame-start output marks beat 0 on the lanes.

Top module: `parity_lane_serializer`

## Requirements
- R1: While rst_ni is low, lane_o, frame_start_o and clk_en_o are all 0.
- R2: frame_start_o is high for exactly one cycle in every 12, and the lanes show beat 0 of a frame in the cycle where it is high.
- R3: Channel n (n = 0, 1, 2) is taken from sample_i[8n+7:8n]. In beats 0 to 7, lane_o[n] carries bit b of channel n in beat b.
- R4: In beat 8, lane_o[n] carries the odd parity bit of channel n (n = 0, 1, 2). That bit makes the 9 bits hold an odd number of ones, so an all-zero or all-one sample gets parity 1.
- R5: Channel 3 is sample_i[31:24]. In beats 9, 10 and 11, lane_o[0] carries its bits 0, 1, 2, lane_o[1] carries bits 3, 4, 5, and lane_o[2] carries bits 6 and 7 in beats 9 and 10.
- R6: In beat 11, lane_o[2] carries the odd parity bit of channel 3.
- R7: Samples are captured only at the edge that starts a frame. A change on sample_i after that edge has no effect on the frame being sent.
- R8: If valid_i is low at the frame-start edge, the frame repeats the previously captured samples.
- R9: After reset release, clk_en_o is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one beat per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 32 | Four packed 8-bit samples, channel 0 in the low byte |
| valid_i | input | 1 | Sample set is valid; sampled at the frame-start edge |
| lane_o | output | 3 | Registered serial data lanes |
| clk_en_o | output | 1 | Bit-clock lane, high every beat after reset |
| frame_start_o | output | 1 | High while the lanes show beat 0 |

## Verification
The counter value b at a clock edge appears on lane_o as beat b after that same edge, with one register stage in between. frame_start_o is registered alongside the lanes. sample_i is captured at the edge that raises frame_start_o. The bench therefore drives new samples on a falling edge, then waits for a falling edge at which frame_start_o is high, and reads the 12 beats at 12 consecutive falling edges from there. This keeps each comparison exactly one register stage after the edge that produced it. The mid-frame and invalid-strobe tests change inputs only after that frame's beat 0 has been observed, or before the next frame edge, so the expected frame is known without doubt.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int SAMPLE_W    = 8;
  localparam int NUM_CH      = 4;
  localparam int NUM_LANES   = NUM_CH - 1;
  localparam int CODED_W     = SAMPLE_W + 1;
  localparam int TAIL_BEATS  = (CODED_W + NUM_LANES - 1) / NUM_LANES;
  localparam int FRAME_BEATS = CODED_W + TAIL_BEATS;
  localparam int BEAT_W      = $clog2(FRAME_BEATS);

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [CODED_W-1:0]  coded_t;
  typedef logic [BEAT_W-1:0]   beat_t;
endpackage

// File: rtl/pls_beat_counter.sv
module pls_beat_counter
  import pls_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output beat_t beat_o,
  output logic  frame_begin_o
);
  localparam beat_t LAST = beat_t'(FRAME_BEATS - 1);

  beat_t beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            beat_q <= '0;
    else if (beat_q == LAST) beat_q <= '0;
    else                    beat_q <= beat_q + beat_t'(1);
  end

  assign beat_o        = beat_q;
  assign frame_begin_o = (beat_q == '0);

  assert_beat_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_q <= LAST);
  assert_beat_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_q == LAST) |=> (beat_q == '0));
endmodule

// File: rtl/pls_parity_gen.sv
module pls_parity_gen
  import pls_pkg::*;
(
  input  sample_t raw_i   [NUM_CH],
  output coded_t  coded_o [NUM_CH]
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // odd parity: total ones across data + parity is odd
    assign coded_o[c] = {~^raw_i[c], raw_i[c]};
  end
endmodule

// File: rtl/pls_lane_mux.sv
module pls_lane_mux
  import pls_pkg::*;
(
  input  coded_t                 coded_i [NUM_CH],
  input  beat_t                  beat_i,
  output logic [NUM_LANES-1:0]   lane_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    coded_t shifted;
    int     pos;
    always_comb begin
      pos = int'(beat_i);
      if (pos < CODED_W) shifted = coded_i[l] >> pos;
      else               shifted = coded_i[NUM_CH-1] >> (l * TAIL_BEATS + pos - CODED_W);
      lane_o[l] = shifted[0];
    end
  end
endmodule

// File: rtl/parity_lane_serializer.sv
module parity_lane_serializer
  import pls_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  input  logic                       valid_i,
  output logic [NUM_LANES-1:0]       lane_o,
  output logic                       clk_en_o,
  output logic                       frame_start_o
);
  beat_t                      beat;
  logic                       frame_begin;
  logic [NUM_CH*SAMPLE_W-1:0] data_q, cur;
  sample_t                    raw   [NUM_CH];
  coded_t                     coded [NUM_CH];
  logic [NUM_LANES-1:0]       lane_nxt, lane_q;
  logic                       fs_q, en_q;

  pls_beat_counter i_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .beat_o        (beat),
    .frame_begin_o (frame_begin)
  );

  // new set bypasses the hold register so beat 0 already uses it
  assign cur = (frame_begin && valid_i) ? sample_i : data_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
    assign raw[c] = cur[c*SAMPLE_W +: SAMPLE_W];
  end

  pls_parity_gen i_par (
    .raw_i   (raw),
    .coded_o (coded)
  );

  pls_lane_mux i_mux (
    .coded_i (coded),
    .beat_i  (beat),
    .lane_o  (lane_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      lane_q <= '0;
      fs_q   <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (frame_begin) data_q <= cur;
      lane_q <= lane_nxt;
      fs_q   <= frame_begin;
      en_q   <= 1'b1;
    end
  end

  assign lane_o        = lane_q;
  assign frame_start_o = fs_q;
  assign clk_en_o      = en_q;

  assert_hold_mid_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_begin |=> $stable(data_q));
  assert_frame_start_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (beat == beat_t'(1)));
  assert_clk_en_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |=> clk_en_o);
endmodule

// File: tb/test_parity_lane_serializer.sv
module test_parity_lane_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sample = '0;
  logic        valid = 1'b0;
  logic [2:0]  lane;
  logic        clk_en, fs;
  int          n_chk = 0, n_fail = 0;
  logic [2:0]  cap [12];

  always #5 clk = ~clk;

  parity_lane_serializer i_parity_lane_serializer (
    .clk_i (clk), .rst_ni (rst_n), .sample_i (sample), .valid_i (valid),
    .lane_o (lane), .clk_en_o (clk_en), .frame_start_o (fs)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] coded(input logic [31:0] s, input int ch);
    return {~^s[ch*8 +: 8], s[ch*8 +: 8]};
  endfunction

  function automatic logic exp_bit(input logic [31:0] s, input int beat, input int ln);
    logic [8:0] w;
    if (beat < 9) begin w = coded(s, ln); return w[beat]; end
    w = coded(s, 3);
    return w[ln*3 + beat - 9];
  endfunction

  task automatic wait_fs();
    do @(negedge clk); while (fs !== 1'b1);
  endtask

  // capture one frame starting at the current beat-0 negedge; optional mid-frame input change
  task automatic capture(input bit change, input logic [31:0] nv);
    cap[0] = lane;
    if (change) sample = nv;
    for (int b = 1; b < 12; b++) begin
      @(negedge clk);
      cap[b] = lane;
    end
  endtask

  task automatic check_frame(input logic [31:0] s, input string tag);
    logic [23:0] a3, e3;
    logic [2:0]  a4, e4;
    logic [8:0]  a5, e5;
    for (int b = 0; b < 8; b++)
      for (int l = 0; l < 3; l++) begin a3[b*3+l] = cap[b][l]; e3[b*3+l] = exp_bit(s, b, l); end
    for (int l = 0; l < 3; l++) begin a4[l] = cap[8][l]; e4[l] = exp_bit(s, 8, l); end
    for (int b = 9; b < 12; b++)
      for (int l = 0; l < 3; l++) begin a5[(b-9)*3+l] = cap[b][l]; e5[(b-9)*3+l] = exp_bit(s, b, l); end
    chk({"R3 ", tag}, 64'(a3), 64'(e3));
    chk({"R4 ", tag}, 64'(a4), 64'(e4));
    chk({"R5 ", tag}, 64'(a5[7:0]), 64'(e5[7:0]));
    chk({"R6 ", tag}, 64'(cap[11][2]), 64'(~^s[31:24]));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 lanes in reset", 64'(lane), 64'(0));
    chk("R1 frame_start in reset", 64'(fs), 64'(0));
    chk("R1 clk_en in reset", 64'(clk_en), 64'(0));
    rst_n = 1'b1;
  endtask

  task automatic t_pattern(input logic [31:0] s, input string tag);
    @(negedge clk);
    sample = s; valid = 1'b1;
    wait_fs();
    capture(1'b0, '0);
    check_frame(s, tag);
  endtask

  task automatic t_period();
    int cnt = 0;
    wait_fs();
    do begin @(negedge clk); cnt++; end while (fs !== 1'b1);
    chk("R2 frame period", 64'(cnt), 64'(12));
  endtask

  task automatic t_midframe();
    logic [31:0] s1 = 32'hC3_0F_A5_96;
    @(negedge clk);
    sample = s1; valid = 1'b1;
    wait_fs();
    capture(1'b1, 32'h3C_F0_5A_69);
    check_frame(s1, "R7 mid-frame change ignored");
    sample = s1;
  endtask

  task automatic t_valid_low();
    logic [31:0] s1 = 32'h81_42_24_18;
    @(negedge clk);
    sample = s1; valid = 1'b1;
    wait_fs();
    @(negedge clk);
    sample = 32'hDE_AD_BE_EF; valid = 1'b0;
    wait_fs();
    capture(1'b0, '0);
    check_frame(s1, "R8 repeat on invalid");
    valid = 1'b1;
  endtask

  task automatic t_clk_en();
    logic all_hi = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (clk_en !== 1'b1) all_hi = 1'b0;
    end
    chk("R9 clk_en high", 64'(all_hi), 64'(1));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pattern(32'h00000000, "zeros");
        t_pattern(32'hFFFFFFFF, "ones");
        t_pattern(32'h01_80_55_AA, "mixed");
        t_pattern(32'h12_34_56_78, "count");
        t_period();
        t_midframe();
        t_valid_low();
        t_clk_en();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule